// File: doc/BRIEF.md
# Four-Pin Pulse-Density Volume Gate

This block sets the loudness of a square-wave tone. It gates the tone onto four output pins, and each pin is switched on and off with its own pulse-density pattern. The pins drive an external nonlinear resistor ladder. The ladder turns the four per-pin duty levels into one combined gain. Each pin's level comes from a 4-bit field of a 16-bit gain word, so there are 65536 gain codes in all.

Every pin has a free-running 4-bit counter that advances on a clock-enable strobe. The strobe runs far faster than the audio rate, so an RC filter can average the pulses. There are two density modes:

- **Linear:** a pin is on for N counts out of every 16.
- **Reciprocal:** a pin gives one strobe-long pulse every N strobes.

While the square wave is low, all pins stay off. Gain and mode values are taken only when a pin's counter wraps to zero, so an update never cuts a pulse short.

Top module: `pdm_vol_gate`

## Requirements
- R1: Each pin counter advances by one on a clock where `tick_i` is 1 and holds otherwise. Reset clears every counter to 0 together.
- R2: Field k of `gain_i` (bits 4k+3 down to 4k) controls only `pin_o[k]`.
- R3: While `square_i` is 0, all of `pin_o` is 0 from the next clock onwards.
- R4: In linear mode (`mode_i` = 0), pin k is high on the clock after its counter holds a value below its latched N. This gives N highs in 16 strobes, starting at count 0. N = 0 keeps the pin low.
- R5: In reciprocal mode (`mode_i` = 1), the counter runs 0..N-1 and the pin is high for the single strobe at count 0. N = 1 keeps the pin high for the whole high half-wave, and N = 0 keeps it low.
- R6: A pin samples its gain field and `mode_i` only on the strobe where its counter wraps to 0. Changes made between wraps have no effect on that pin until then.
- R7: Reset clears all latched gains to 0, so every pin stays low until the first wrap at the 16th strobe after reset. The new setting shows on the pins one clock after that wrap.
- R8: With `tick_i` at 0 and `square_i` steady, `pin_o` does not change. Each pin's output is registered, one clock after its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock-enable strobe |
| square_i | input | 1 | Square-wave tone bit |
| gain_i | input | 16 | Four 4-bit per-pin gain fields; field k drives pin k |
| mode_i | input | 1 | 0 linear density, 1 reciprocal density |
| pin_o | output | 4 | Gated pin drives to the resistor ladder |

## Verification
The bench goes after the following corner cases:

- **Zero and full gain in both modes.** Here a wrong compare shows as a stray pulse at N = 0, or as a gap at reciprocal N = 1.
- **Field-to-pin mapping.** Distinct field values reveal swapped nibbles.
- **Gain change in mid-period.** A design that latched at once would switch the pin early, inside a period.
- **Strobe freeze.** This catches a counter that runs without the strobe.
- **Start-up after reset.** This exposes shadows or counters that do not reset together, since the pins would then leave 0 before the 16th strobe.

// File: rtl/pdm_vol_pkg.sv
package pdm_vol_pkg;
  typedef enum logic {
    MODE_LIN   = 1'b0,
    MODE_RECIP = 1'b1
  } pdm_mode_e;
endpackage

// File: rtl/pdm_vol_seq.sv
// Per-pin counter with gain/mode shadow loaded on wrap
module pdm_vol_seq
  import pdm_vol_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] gain_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] gain_q_o,
  output logic             mode_q_o
);
  logic [CNT_W-1:0] cnt_q, gain_q, last;
  logic             mode_q, wrap;

  always_comb begin
    if (pdm_mode_e'(mode_q) == MODE_RECIP && gain_q != '0) last = gain_q - 1'b1;
    else                                                   last = '1;
  end

  assign wrap = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gain_q <= '0;
      mode_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) begin
        gain_q <= gain_i;
        mode_q <= mode_i;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign gain_q_o = gain_q;
  assign mode_q_o = mode_q;
endmodule

// File: rtl/pdm_vol_drive.sv
// Density decode and registered pin drive
module pdm_vol_drive
  import pdm_vol_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             square_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] gain_i,
  input  logic             mode_i,
  output logic             pin_o
);
  logic on, pin_q;

  always_comb begin
    unique case (pdm_mode_e'(mode_i))
      MODE_RECIP: on = (gain_i != '0) && (cnt_i == '0);
      default:    on = cnt_i < gain_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= square_i & on;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/pdm_vol_gate.sv
module pdm_vol_gate #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned CNT_W    = 4,
  localparam int unsigned GAIN_W  = NUM_PINS * CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                square_i,
  input  logic [GAIN_W-1:0]   gain_i,
  input  logic                mode_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [GAIN_W-1:0]   gain_q_all;
  logic [NUM_PINS-1:0] mode_q_all;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic [CNT_W-1:0] cnt;

    pdm_vol_seq #(.CNT_W(CNT_W)) u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .gain_i   (gain_i[k*CNT_W +: CNT_W]),
      .mode_i   (mode_i),
      .cnt_o    (cnt),
      .gain_q_o (gain_q_all[k*CNT_W +: CNT_W]),
      .mode_q_o (mode_q_all[k])
    );

    pdm_vol_drive #(.CNT_W(CNT_W)) u_drive (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .square_i (square_i),
      .cnt_i    (cnt),
      .gain_i   (gain_q_all[k*CNT_W +: CNT_W]),
      .mode_i   (mode_q_all[k]),
      .pin_o    (pin_o[k])
    );
  end
endmodule

// File: rtl/pdm_vol_gate_chk.sv
module pdm_vol_gate_chk #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned CNT_W    = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         tick_i,
  input logic                         square_i,
  input logic [NUM_PINS-1:0]          pin_o,
  input logic [NUM_PINS*CNT_W-1:0]    gain_q_all,
  input logic [NUM_PINS-1:0]          mode_q_all
);
  logic [NUM_PINS-1:0] zero_mask, one_mask;

  always_comb begin
    for (int k = 0; k < NUM_PINS; k++) begin
      zero_mask[k] = gain_q_all[k*CNT_W +: CNT_W] == '0;
      one_mask[k]  = mode_q_all[k] && (gain_q_all[k*CNT_W +: CNT_W] == CNT_W'(1));
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_PINS_LOW: assert (pin_o == '0); // R7
  end

  AST_SQUARE_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !square_i |=> pin_o == '0); // R3

  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && $past(!tick_i) && $stable(square_i)) |=> $stable(pin_o)); // R8

  AST_ZERO_GAIN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_mask != '0) |=> (pin_o & $past(zero_mask)) == '0); // R4

  AST_RECIP_ONE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (square_i && one_mask != '0) |=> (pin_o & $past(one_mask)) == $past(one_mask)); // R5

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(gain_q_all) && $stable(mode_q_all)); // R6
endmodule

bind pdm_vol_gate pdm_vol_gate_chk #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .square_i   (square_i),
  .pin_o      (pin_o),
  .gain_q_all (gain_q_all),
  .mode_q_all (mode_q_all)
);

// File: tb/pdm_vol_gate_tb.sv
`timescale 1ns/1ps
module pdm_vol_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 240;
  localparam int NVEC       = 7;
  // bit 16 = mode, bits 15:0 = gain word
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 16'h0F84}, {1'b0, 16'h1234}, {1'b0, 16'hFFFF},
    {1'b1, 16'h0F84}, {1'b1, 16'h1235}, {1'b1, 16'hCA65}, {1'b1, 16'h1111}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, square_i = 1'b1, mode_i = 1'b0;
  logic [15:0] gain_i = '0;
  logic [3:0]  pin_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pdm_vol_gate u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .square_i(square_i),
    .gain_i(gain_i), .mode_i(mode_i), .pin_o(pin_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // After return: negedge right after reset release; next posedge is strobe 1
  task automatic do_reset(input logic [15:0] g, input logic m);
    @(negedge clk_i);
    rst_ni = 1'b0; gain_i = g; mode_i = m; tick_i = 1'b1; square_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic int exp_highs(input logic m, input int n);
    if (m) return (n == 0) ? 0 : WIN / n;
    return (WIN / 16) * n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt [4];
    int pat;
    int bad;

    // R4 R5 R2: duty table, one pattern per vector
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][15:0], VEC[v][16]);
      step(17);
      for (int k = 0; k < 4; k++) cnt[k] = 0;
      for (int s = 0; s < WIN; s++) begin
        for (int k = 0; k < 4; k++) cnt[k] += int'(pin_o[k]);
        step(1);
      end
      for (int k = 0; k < 4; k++)
        check(cnt[k] == exp_highs(VEC[v][16], int'(VEC[v][15:0] >> (4*k)) & 15),
              VEC[v][16] ? "R5/R2 recip duty" : "R4/R2 lin duty",
              cnt[k], exp_highs(VEC[v][16], int'(VEC[v][15:0] >> (4*k)) & 15));
    end

    // R7: reset state and first latch at strobe 16
    do_reset(16'hFFFF, 1'b0);
    check(pin_o == 4'h0, "R7 reset pins low", pin_o, 0);
    step(16);
    check(pin_o == 4'h0, "R7 low through strobe 16", pin_o, 0);
    step(1);
    check(pin_o == 4'hF, "R7 gain visible after first wrap", pin_o, 15);

    // R4: linear N=3 gives highs at counts 0..2
    do_reset(16'h0003, 1'b0);
    step(17);
    pat = 0;
    for (int s = 0; s < 16; s++) begin pat |= int'(pin_o[0]) << s; step(1); end
    check(pat == 16'h0007, "R4 lin N=3 pattern", pat, 16'h0007);

    // R5: reciprocal N=4 gives one high every 4 strobes
    do_reset(16'h0004, 1'b1);
    step(17);
    pat = 0;
    for (int s = 0; s < 16; s++) begin pat |= int'(pin_o[0]) << s; step(1); end
    check(pat == 16'h1111, "R5 recip N=4 pattern", pat, 16'h1111);

    // R6: mid-period change waits for wrap
    do_reset(16'h0008, 1'b0);
    step(19);                       // count after P19 = 3
    gain_i = 16'h000F;
    step(8);                        // pin after P27 reflects count 10, N still 8
    check(pin_o[0] == 1'b0, "R6 old gain held until wrap", pin_o[0], 0);
    step(16);                       // pin after P43 reflects count 10, N now 15
    check(pin_o[0] == 1'b1, "R6 new gain after wrap", pin_o[0], 1);

    // R3: square low forces all pins off
    do_reset(16'hFFFF, 1'b0);
    step(20);
    square_i = 1'b0;
    bad = 0;
    for (int s = 0; s < 20; s++) begin step(1); if (pin_o != 4'h0) bad++; end
    check(bad == 0, "R3 square low pins off", bad, 0);
    square_i = 1'b1;

    // R8 R1: strobe freeze holds pins, then counting resumes
    do_reset(16'h0001, 1'b0);
    step(16);                       // count 0 latched
    tick_i = 1'b0;
    bad = 0;
    for (int s = 0; s < 20; s++) begin step(1); if (pin_o[0] != 1'b1) bad++; end
    check(bad == 0, "R8 frozen strobe holds pin", bad, 0);
    tick_i = 1'b1;
    step(2);
    check(pin_o[0] == 1'b0, "R1 counter resumes after strobe", pin_o[0], 0);
    step(15);
    check(pin_o[0] == 1'b1, "R1 wrap to 0 after 16 strobes", pin_o[0], 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule